// File: doc/BRIEF.md
# Timebase Timer with Edge Capture

This peripheral provides a periodic timebase and a time-stamp capture for edges on an external pin. A free-running prescaler counts oscillator clocks and wraps after one of two fixed intervals; each wrap raises a timebase flag. An 8-bit up-counter advances every clock. When the capture pin changes level, the counter value is copied into a capture register and a capture flag is raised.

Software reaches the block through a synchronous address/data port with three byte registers at consecutive addresses: address 0 is the counter, address 1 is the control/status register and address 2 is the capture register. Address 3 reads zero. Read data is combinational from the address in the same cycle. A read strobe on the status address clears both flags at the next clock edge. A single interrupt line combines the two flags with their enables.

Top module: `tbcap_timer`

## Requirements
- R1: After a synchronous active-low reset, every register reads 00h and `irq` is low.
- R2: With the period select bit (status bit 5) at 0, the timebase flag (status bit 3) sets once every SHORT_CYC clocks. With it at 1, the flag sets once every LONG_CYC clocks. The first flag after reset appears SHORT_CYC clocks after reset is released.
- R3: A read strobe on address 1 clears the timebase flag and the capture flag at the next edge. Writes to bits 6 and 3 have no effect on either flag.
- R4: If a timebase wrap occurs in the same cycle as a status read, the timebase flag is left set.
- R5: Status bits 7 (capture interrupt enable), 5 and 4 (timebase interrupt enable) are written from bus_wdata and read back. `irq` equals (bit 3 AND bit 4) OR (bit 6 AND bit 7).
- R6: A rising or a falling level change on `cap_in` copies the counter into the capture register and sets the capture flag (status bit 6). The value captured is the counter read at the moment `cap_in` changed, plus SYNC_STAGES.
- R7: While the capture flag is set, further edges do not change the capture register. A status read clears the flag and re-arms capture.
- R8: The counter (address 0) and the capture register (address 2) ignore bus writes.
- R9: Status bits 2:0 always read 0, and address 3 always reads 00h.
- R10: The counter increments by one every clock and wraps from FFh to 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears flags on address 1) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| cap_in | input | 1 | Asynchronous capture pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with SHORT_CYC=40 and LONG_CYC=90 instead of the default values. This makes many timebase wraps, a switch between the two periods while the prescaler is mid-count, and a status read that coincides exactly with a wrap all reachable within a few thousand cycles. A non-multiple long period checks that a period change uses the new limit from the current count. SYNC_STAGES keeps its default of 2, so the capture latency and the captured value offset are exercised as specified.

// File: rtl/tbcap_pkg.sv
// Shared constants for the timebase/capture timer.
// Assumes an 8-bit data bus and a 2-bit byte address.
package tbcap_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_CNT  = 2'd0,
        ADDR_STAT = 2'd1,
        ADDR_CAP  = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    // Status register bit positions
    localparam int ST_CIE  = 7;
    localparam int ST_CF   = 6;
    localparam int ST_PSEL = 5;
    localparam int ST_TIE  = 4;
    localparam int ST_TF   = 3;
endpackage

// File: rtl/tbcap_prescaler.sv
// Timebase prescaler: counts clocks and pulses tick on the last count of
// the selected interval, then restarts from zero.
// Assumes SHORT_CYC < LONG_CYC and both >= 2. The sel input may change at any
// time; a count already past the new limit wraps at the next edge.
module tbcap_prescaler #(
    parameter int SHORT_CYC = 8000,
    parameter int LONG_CYC  = 16000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic long_sel,
    output logic tick
);
    localparam int PW = $clog2(LONG_CYC + 1);
    localparam logic [PW-1:0] LIM_S = PW'(SHORT_CYC - 1);
    localparam logic [PW-1:0] LIM_L = PW'(LONG_CYC - 1);

    logic [PW-1:0] cnt_q;
    logic [PW-1:0] limit;

    // Select the terminal count for the current period
    always_comb limit = long_sel ? LIM_L : LIM_S;

    // Wrap detection on the registered count
    always_comb tick = (cnt_q >= limit);

    // Advance or restart the prescale count
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    // R2
    presc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < PW'(LONG_CYC));
    // R2
    presc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0));
endmodule

// File: rtl/tbcap_capture.sv
// Free-running 8-bit counter plus edge capture. The pin passes through a
// SYNC_STAGES flop synchronizer, one more flop gives the previous level, and
// any level change while 'arm' is high copies the counter into cap_q.
// Assumes SYNC_STAGES >= 2 and cap_pin asynchronous to clk.
module tbcap_capture
    import tbcap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_pin,
    input  logic              arm,
    output logic [DATA_W-1:0] cnt_val,
    output logic [DATA_W-1:0] cap_val,
    output logic              cap_event
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic [DATA_W-1:0]      cnt_q;
    logic [DATA_W-1:0]      cap_q;
    logic                   lvl_chg;

    // Synchronizer shift chain for the capture pin
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], cap_pin};
    end

    // Previous synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    // Both-edge detection gated by the arm input
    always_comb begin
        lvl_chg   = sync_q[SYNC_STAGES-1] ^ prev_q;
        cap_event = lvl_chg & arm;
    end

    // Free-running up-counter
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    // Capture register load
    always_ff @(posedge clk) begin
        if (!rst_n)         cap_q <= '0;
        else if (cap_event) cap_q <= cnt_q;
    end

    assign cnt_val = cnt_q;
    assign cap_val = cap_q;

    // R10
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt_q == DATA_W'($past(cnt_q) + 1'b1)));
    // R6
    cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_event |=> (cap_q == $past(cnt_q)));
    // R7
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> $stable(cap_q));
endmodule

// File: rtl/tbcap_regs.sv
// Register bank: control bits, the two event flags, the read mux and the
// interrupt combine. A status read clears both flags, but a flag event in
// the same cycle wins over the clear.
// Assumes the bus strobes are synchronous to clk.
module tbcap_regs
    import tbcap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              tb_tick,
    input  logic              cap_event,
    input  logic [DATA_W-1:0] cnt_val,
    input  logic [DATA_W-1:0] cap_val,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              long_sel,
    output logic              cap_armed,
    output logic              irq
);
    logic cie_q, psel_q, tie_q;
    logic tf_q, cf_q;
    logic stat_rd, stat_wr;

    // Decode status-register accesses
    always_comb begin
        stat_rd = bus_rd && (bus_addr == ADDR_STAT);
        stat_wr = bus_wr && (bus_addr == ADDR_STAT);
    end

    // Software-owned control bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cie_q  <= 1'b0;
            psel_q <= 1'b0;
            tie_q  <= 1'b0;
        end else if (stat_wr) begin
            cie_q  <= bus_wdata[ST_CIE];
            psel_q <= bus_wdata[ST_PSEL];
            tie_q  <= bus_wdata[ST_TIE];
        end
    end

    // Timebase flag: set by wrap, cleared by status read, set has priority
    always_ff @(posedge clk) begin
        if (!rst_n) tf_q <= 1'b0;
        else        tf_q <= tb_tick | (tf_q & ~stat_rd);
    end

    // Capture flag: set by capture, cleared by status read, set has priority
    always_ff @(posedge clk) begin
        if (!rst_n) cf_q <= 1'b0;
        else        cf_q <= cap_event | (cf_q & ~stat_rd);
    end

    // Read data multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CNT:  bus_rdata = cnt_val;
            ADDR_STAT: begin
                bus_rdata[ST_CIE]  = cie_q;
                bus_rdata[ST_CF]   = cf_q;
                bus_rdata[ST_PSEL] = psel_q;
                bus_rdata[ST_TIE]  = tie_q;
                bus_rdata[ST_TF]   = tf_q;
            end
            ADDR_CAP:  bus_rdata = cap_val;
            default:   bus_rdata = '0;
        endcase
    end

    // Outputs to the timer datapath and interrupt combine
    always_comb begin
        long_sel  = psel_q;
        cap_armed = ~cf_q;
        irq       = (tf_q & tie_q) | (cf_q & cie_q);
    end

    // R4
    tf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tb_tick |=> tf_q);
    // R3
    tf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !tb_tick) |=> !tf_q);
    // R7
    cf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_event |=> cf_q);
endmodule

// File: rtl/tbcap_timer.sv
// Top level of the timebase timer with edge capture. Connects the prescaler,
// the counter/capture path and the register bank.
// Assumes a single clock domain except for cap_in, which is synchronized.
module tbcap_timer
    import tbcap_pkg::*;
#(
    parameter int SHORT_CYC   = 8000,
    parameter int LONG_CYC    = 16000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cap_in,
    output logic              irq
);
    logic              tb_tick;
    logic              long_sel;
    logic              cap_armed;
    logic              cap_event;
    logic [DATA_W-1:0] cnt_val;
    logic [DATA_W-1:0] cap_val;

    tbcap_prescaler #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_presc (
        .clk(clk), .rst_n(rst_n), .long_sel(long_sel), .tick(tb_tick)
    );

    tbcap_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
        .clk(clk), .rst_n(rst_n), .cap_pin(cap_in), .arm(cap_armed),
        .cnt_val(cnt_val), .cap_val(cap_val), .cap_event(cap_event)
    );

    tbcap_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .tb_tick(tb_tick),
        .cap_event(cap_event), .cnt_val(cnt_val), .cap_val(cap_val),
        .bus_rdata(bus_rdata), .long_sel(long_sel), .cap_armed(cap_armed),
        .irq(irq)
    );

    // R9
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_STAT) |-> (bus_rdata[2:0] == 3'b000));
    // R9
    none_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_NONE) |-> (bus_rdata == '0));
endmodule

// File: tb/test_tbcap_timer.sv
`timescale 1ns/1ps
module test_tbcap_timer;
    localparam int SHORT_P = 40;
    localparam int LONG_P  = 90;
    localparam int SYNC    = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       cap_in = 1'b0;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;
    bit started = 0;

    // behavioural reference state
    int m_pres, m_cnt, m_cap;
    bit m_cie, m_psel, m_tie, m_tf, m_cf, m_prev;
    bit m_sync[SYNC];

    tbcap_timer #(.SHORT_CYC(SHORT_P), .LONG_CYC(LONG_P), .SYNC_STAGES(SYNC)) i_tbcap_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_in(cap_in), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int exp_rdata(input logic [1:0] a);
        case (a)
            2'd0: return m_cnt;
            2'd1: return (int'(m_cie) << 7) | (int'(m_cf) << 6) | (int'(m_psel) << 5)
                       | (int'(m_tie) << 4) | (int'(m_tf) << 3);
            2'd2: return m_cap;
            default: return 0;
        endcase
    endfunction

    // reference model, advanced on every rising edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_pres = 0; m_cnt = 0; m_cap = 0;
            m_cie = 0; m_psel = 0; m_tie = 0; m_tf = 0; m_cf = 0; m_prev = 0;
            for (int i = 0; i < SYNC; i++) m_sync[i] = 0;
            started = 1;
        end else begin
            int lim;
            bit tick, rd_st, edg, cap;
            lim   = m_psel ? LONG_P - 1 : SHORT_P - 1;
            tick  = (m_pres >= lim);
            rd_st = bus_rd && (bus_addr == 2'd1);
            edg   = (m_sync[SYNC-1] != m_prev);
            cap   = edg && !m_cf;
            m_tf  = tick || (m_tf && !rd_st);
            m_cf  = cap || (m_cf && !rd_st);
            if (cap) m_cap = m_cnt;
            m_cnt  = (m_cnt + 1) % 256;
            m_pres = tick ? 0 : m_pres + 1;
            if (bus_wr && bus_addr == 2'd1) begin
                m_cie = bus_wdata[7]; m_psel = bus_wdata[5]; m_tie = bus_wdata[4];
            end
            m_prev = m_sync[SYNC-1];
            for (int i = SYNC - 1; i > 0; i--) m_sync[i] = m_sync[i-1];
            m_sync[0] = cap_in;
        end
    end

    // per-cycle comparison against the model, away from the clock edge
    always @(negedge clk) begin
        if (started && !done) begin
            case (bus_addr)
                2'd0: chk("R10 counter", bus_rdata, exp_rdata(bus_addr));
                2'd1: chk("R3 status", bus_rdata, exp_rdata(bus_addr));
                2'd2: chk("R6 capture", bus_rdata, exp_rdata(bus_addr));
                default: chk("R9 unused address", bus_rdata, 0);
            endcase
            chk("R5 irq", irq, int'((m_tf && m_tie) || (m_cf && m_cie)));
        end
    end

    // drive one bus cycle, applied 2 ns after the rising edge
    task automatic step(input logic [1:0] a, input bit rd, input bit wr, input logic [7:0] d);
        @(posedge clk); #2;
        bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(bus_addr, 0, 0, 8'h00);
    endtask

    task automatic wait_tf_rise(output int t);
        bit prv, now, found;
        prv = bus_rdata[3];
        do begin
            @(negedge clk);
            now = bus_rdata[3];
            found = !prv && now;
            prv = now;
        end while (!found);
        t = cyc;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int t1, t2, c0, capv;
        // R1: reset state of every address
        repeat (3) @(posedge clk);
        for (int a = 0; a < 4; a++) begin
            #2 bus_addr = 2'(a);
            @(negedge clk);
            chk("R1 reset value", bus_rdata, 0);
            chk("R1 reset irq", irq, 0);
            @(posedge clk);
        end
        #2 rst_n = 1; bus_addr = 2'd1;

        // R2: short period, measured on the flag without clearing reads
        step(2'd1, 0, 1, 8'h10);
        step(2'd1, 0, 0, 8'h00);
        wait_tf_rise(t1);
        step(2'd1, 1, 0, 8'h00);
        step(2'd1, 0, 0, 8'h00);
        wait_tf_rise(t2);
        chk("R2 short period", t2 - t1, SHORT_P);

        // R2: long period after switching mid-count
        step(2'd1, 1, 1, 8'h30);
        step(2'd1, 0, 0, 8'h00);
        wait_tf_rise(t1);
        step(2'd1, 1, 0, 8'h00);
        step(2'd1, 0, 0, 8'h00);
        wait_tf_rise(t2);
        chk("R2 long period", t2 - t1, LONG_P);

        // R3: writing the flag bits does not set them
        step(2'd1, 1, 0, 8'h00);
        step(2'd1, 0, 1, 8'h48);
        step(2'd1, 0, 0, 8'h00);
        @(negedge clk);
        chk("R3 write to flags ignored", bus_rdata & 8'h48, 0);
        chk("R5 control readback", bus_rdata & 8'hB0, 0);

        // R4: status read exactly on the wrap cycle keeps the flag
        step(2'd1, 0, 1, 8'h10);
        do begin @(posedge clk); #1; end while (m_pres != SHORT_P - 1);
        #1 bus_rd = 1;
        @(posedge clk); #2 bus_rd = 0;
        @(negedge clk);
        chk("R4 flag survives coincident read", bus_rdata[3], 1);
        chk("R5 timebase irq", irq, 1);

        // R9: reserved bits after writing all ones
        step(2'd1, 1, 1, 8'hFF);
        step(2'd1, 0, 0, 8'h00);
        @(negedge clk);
        chk("R9 reserved bits zero", bus_rdata & 8'h07, 0);
        chk("R5 enables readback", bus_rdata & 8'hB0, 8'hB0);
        step(2'd1, 0, 1, 8'h80);
        step(2'd1, 1, 0, 8'h00);

        // R6: rising edge capture value
        @(posedge clk); #2 bus_rd = 0; bus_addr = 2'd0; cap_in = 1;
        #1 c0 = bus_rdata;
        idle(SYNC + 2);
        step(2'd2, 0, 0, 8'h00);
        @(negedge clk);
        capv = (c0 + SYNC) % 256;
        chk("R6 rising capture value", bus_rdata, capv);
        chk("R7 capture irq", irq, 1);

        // R7: further edges blocked while flag is set
        cap_in = 0;
        idle(6);
        @(negedge clk);
        chk("R7 capture held", bus_rdata, capv);

        // R8: writes to counter and capture ignored
        step(2'd2, 0, 1, 8'h5A);
        step(2'd0, 0, 1, 8'hA5);
        step(2'd2, 0, 0, 8'h00);
        @(negedge clk);
        chk("R8 capture write ignored", bus_rdata, capv);

        // R7: status read re-arms; R6 falling edge capture
        step(2'd1, 1, 0, 8'h00);
        step(2'd1, 0, 0, 8'h00);
        @(negedge clk);
        chk("R7 flag cleared by read", bus_rdata[6], 0);
        @(posedge clk); #2 bus_addr = 2'd0; cap_in = 0;
        idle(2);
        @(posedge clk); #2 cap_in = 1;
        #1 c0 = bus_rdata;
        @(posedge clk); #2 cap_in = 0;
        idle(SYNC + 3);
        step(2'd2, 0, 0, 8'h00);
        @(negedge clk);
        chk("R6 first edge after re-arm", bus_rdata, (c0 + SYNC) % 256);

        // R10: counter wraps from FFh to 00h
        step(2'd0, 0, 0, 8'h00);
        do @(negedge clk); while (bus_rdata != 8'hFF);
        @(negedge clk);
        chk("R10 counter wrap", bus_rdata, 0);

        // R9: unused address
        step(2'd3, 0, 1, 8'hFF);
        step(2'd3, 0, 0, 8'h00);
        @(negedge clk);
        chk("R9 unused address", bus_rdata, 0);

        // long run with mixed traffic, compared by the model every cycle
        for (int k = 0; k < 600; k++) begin
            if (k % 37 == 0) cap_in = ~cap_in;
            step(2'(k % 4), (k % 29 == 0), 0, 8'h00);
        end

        // R1: reset again mid-operation
        @(posedge clk); #2 rst_n = 0; bus_addr = 2'd1;
        @(negedge clk); @(negedge clk);
        chk("R1 status after reset", bus_rdata, 0);
        chk("R1 irq after reset", irq, 0);
        idle(2);
        finish_run();
    end
endmodule